// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns one I/O virtual address into a final page table entry. It reads a four-level radix table out of memory, one entry at a time. A request carries the virtual address, a flag that marks the access as a write, and a 64-bit descriptor word. The descriptor word holds the table root and a 2-bit depth-mode field. The walker then issues 64-bit entry reads over a simple valid/ready request port. The memory answers on a response channel that has an error flag.

When the walk ends, the block reports five results. These are the entry that terminated the walk, the level where that entry was found, the read and write permissions gathered along the path, and a fault code. Early termination on large pages is supported. The permission bits of every level visited are combined.

The walker serves one translation at a time. A caller waits for the single-cycle completion pulse before it offers the next request. Caching of results, descriptor fetch and fault logging live outside this block.

Top module: `pt_walker`

## Requirements
- R1: The start level is 4 plus descriptor bits [3:2]. Any result other than 4 ends the request with fault code 1, without any memory read. In that case the level is 0 and both permissions are 0.
- R2: The root base is the descriptor with bits [11:0] cleared. The first read goes to level 4. Each read address is base + 8 * iova[12+(L-1)*9 +: 9], where L is the current level.
- R3: A read that comes back with the error flag set ends the walk. At level 4 the fault code is 2. At any lower level the fault code is 3. The reported level is the level of the failing read, and both permissions are 0.
- R4: An entry with bit 0 clear (not present) ends the walk. The fault code is 3, the level is the level of that entry, and both permissions are 0.
- R5: When a walk succeeds, the read permission is 1. The write permission is the AND of entry bit 1 over every level visited.
- R6: For a write request, an entry with bit 1 clear stops the walk at once. The fault code is 4, no further read is issued, the read permission is 1 and the write permission is 0.
- R7: An entry is a leaf at level 1, or when its bit 7 is set. The walk then ends with fault code 0, the entry on the result port and the leaf level. On every fault the result entry is 0.
- R8: For a non-leaf entry, the next table base is the entry with bits [11:0] cleared and every bit at or above the host address width cleared. The level then drops by one.
- R9: The request ready signal is high only while the block is idle. Busy rises on the cycle after acceptance and stays high through a one-cycle done pulse. Busy is low again on the cycle after done.
- R10: A memory read request keeps its address stable until it is accepted. Only one read is outstanding at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request accepted on this edge |
| req_iova | input | VA_W | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_desc | input | PA_W | Descriptor word: root pointer and depth mode |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry value |
| mem_rsp_err | input | 1 | Read failed |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse; results valid |
| res_entry | output | 64 | Terminal entry, 0 on fault |
| res_level | output | 3 | Level where the walk ended |
| res_read | output | 1 | Read permission |
| res_write | output | 1 | Write permission |
| res_fault | output | 3 | 0 ok, 1 bad descriptor, 2 root read error, 3 entry invalid, 4 write denied |

## Verification
A corrupted level counter or base register shows up as a wrong read address on the very next memory request. Because the bench serves reads from its own table image, that wrong address turns into a non-present entry and a different fault code at done, within a few cycles. A broken permission accumulator or fault selector does not change the address stream. It appears only in the results sampled on the done pulse. Randomised memory ready and latency exercise the hold-until-accepted rule and the single-outstanding rule while walks are in flight.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CHECK = 3'd1,
        ST_ISSUE = 3'd2,
        ST_WAIT  = 3'd3,
        ST_EVAL  = 3'd4,
        ST_DONE  = 3'd5
    } walk_state_e;

    typedef enum logic [2:0] {
        FLT_NONE      = 3'd0,
        FLT_BAD_DESC  = 3'd1,
        FLT_ROOT_READ = 3'd2,
        FLT_ENTRY_INV = 3'd3,
        FLT_WRITE     = 3'd4
    } walk_fault_e;

    localparam int unsigned ENTRY_W    = 64;
    localparam int unsigned IDX_BITS   = 9;
    localparam int unsigned PAGE_SHIFT = 12;
    localparam int unsigned ENT_SHIFT  = 3;
    localparam int unsigned ROOT_LEVEL = 4;
    localparam int unsigned MODE_LSB   = 2;
    localparam int unsigned BIT_PRES   = 0;
    localparam int unsigned BIT_RW     = 1;
    localparam int unsigned BIT_LARGE  = 7;

endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr
    import pt_walker_pkg::*;
#(
    parameter int unsigned VA_W   = 48,
    parameter int unsigned PA_W   = 64,
    parameter int unsigned LEVELS = 4,
    parameter int unsigned LVL_W  = 3
) (
    input  logic [PA_W-1:0]  base,
    input  logic [VA_W-1:0]  iova,
    input  logic [LVL_W-1:0] level,
    output logic [PA_W-1:0]  addr
);
    logic [IDX_BITS-1:0] idx_tab [LEVELS];
    logic [IDX_BITS-1:0] idx;

    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign idx_tab[g] = iova[PAGE_SHIFT + g*IDX_BITS +: IDX_BITS];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (level == LVL_W'(i + 1)) idx = idx_tab[i];
        end
    end

    assign addr = base + PA_W'({idx, {ENT_SHIFT{1'b0}}});
endmodule

// File: rtl/pt_entry_decode.sv
module pt_entry_decode
    import pt_walker_pkg::*;
#(
    parameter int unsigned HAW   = 48,
    parameter int unsigned PA_W  = 64,
    parameter int unsigned LVL_W = 3
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic [LVL_W-1:0]   level,
    output logic               present,
    output logic               writable,
    output logic               leaf,
    output logic [PA_W-1:0]    next_base
);
    localparam logic [ENTRY_W-1:0] BASE_MASK =
        ((ENTRY_W'(1) << HAW) - ENTRY_W'(1)) & ~((ENTRY_W'(1) << PAGE_SHIFT) - ENTRY_W'(1));

    assign present   = entry[BIT_PRES];
    assign writable  = entry[BIT_RW];
    assign leaf      = (level == LVL_W'(1)) || entry[BIT_LARGE];
    assign next_base = PA_W'(entry & BASE_MASK);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int unsigned VA_W = 48,
    parameter int unsigned PA_W = 64,
    parameter int unsigned HAW  = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_iova,
    input  logic            req_write,
    input  logic [PA_W-1:0] req_desc,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [PA_W-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [63:0]     mem_rsp_data,
    input  logic            mem_rsp_err,
    output logic            busy,
    output logic            done,
    output logic [63:0]     res_entry,
    output logic [2:0]      res_level,
    output logic            res_read,
    output logic            res_write,
    output logic [2:0]      res_fault
);
    localparam int unsigned LVL_W = 3;

    typedef struct packed {
        walk_state_e        st;
        logic [VA_W-1:0]    iova;
        logic               wr;
        logic [1:0]         mode;
        logic [PA_W-1:0]    base;
        logic [LVL_W-1:0]   lvl;
        logic               wacc;
        logic [ENTRY_W-1:0] ent;
        logic [ENTRY_W-1:0] r_ent;
        logic [LVL_W-1:0]   r_lvl;
        logic               r_rd;
        logic               r_wr;
        walk_fault_e        r_flt;
    } walk_regs_t;

    walk_regs_t q, d;

    logic             e_present, e_writable, e_leaf;
    logic [PA_W-1:0]  e_next;
    logic [PA_W-1:0]  rd_addr;
    logic [LVL_W-1:0] start_lvl;

    pt_entry_addr #(.VA_W(VA_W), .PA_W(PA_W), .LEVELS(ROOT_LEVEL), .LVL_W(LVL_W)) addr_i (
        .base (q.base),
        .iova (q.iova),
        .level(q.lvl),
        .addr (rd_addr)
    );

    pt_entry_decode #(.HAW(HAW), .PA_W(PA_W), .LVL_W(LVL_W)) dec_i (
        .entry    (q.ent),
        .level    (q.lvl),
        .present  (e_present),
        .writable (e_writable),
        .leaf     (e_leaf),
        .next_base(e_next)
    );

    assign start_lvl = LVL_W'(ROOT_LEVEL) + LVL_W'(q.mode);

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st    = ST_CHECK;
                    d.iova  = req_iova;
                    d.wr    = req_write;
                    d.mode  = req_desc[MODE_LSB +: 2];
                    d.base  = {req_desc[PA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
                    d.r_ent = '0;
                    d.r_lvl = '0;
                    d.r_rd  = 1'b0;
                    d.r_wr  = 1'b0;
                    d.r_flt = FLT_NONE;
                end
            end
            ST_CHECK: begin
                if (start_lvl != LVL_W'(ROOT_LEVEL)) begin
                    d.r_flt = FLT_BAD_DESC;
                    d.st    = ST_DONE;
                end else begin
                    d.lvl  = start_lvl;
                    d.wacc = 1'b1;
                    d.st   = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (mem_req_ready) d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        d.r_flt = (q.lvl == LVL_W'(ROOT_LEVEL)) ? FLT_ROOT_READ : FLT_ENTRY_INV;
                        d.r_lvl = q.lvl;
                        d.st    = ST_DONE;
                    end else begin
                        d.ent = mem_rsp_data;
                        d.st  = ST_EVAL;
                    end
                end
            end
            ST_EVAL: begin
                d.r_lvl = q.lvl;
                if (!e_present) begin
                    d.r_flt = FLT_ENTRY_INV;
                    d.st    = ST_DONE;
                end else if (q.wr && !e_writable) begin
                    d.r_flt = FLT_WRITE;
                    d.r_rd  = 1'b1;
                    d.st    = ST_DONE;
                end else begin
                    d.wacc = q.wacc & e_writable;
                    if (e_leaf) begin
                        d.r_ent = q.ent;
                        d.r_rd  = 1'b1;
                        d.r_wr  = q.wacc & e_writable;
                        d.st    = ST_DONE;
                    end else begin
                        d.base = e_next;
                        d.lvl  = q.lvl - LVL_W'(1);
                        d.st   = ST_ISSUE;
                    end
                end
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready     = (q.st == ST_IDLE);
    assign busy          = (q.st != ST_IDLE);
    assign done          = (q.st == ST_DONE);
    assign mem_req_valid = (q.st == ST_ISSUE);
    assign mem_req_addr  = rd_addr;
    assign res_entry     = q.r_ent;
    assign res_level     = q.r_lvl;
    assign res_read      = q.r_rd;
    assign res_write     = q.r_wr;
    assign res_fault     = q.r_flt;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int unsigned PA_W = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            mem_rsp_valid,
    input logic            busy,
    input logic            done,
    input logic [2:0]      res_level,
    input logic            res_read,
    input logic            res_write,
    input logic [2:0]      res_fault
);
    logic outst_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                             outst_q <= 1'b0;
        else if (mem_req_valid && mem_req_ready) outst_q <= 1'b1;
        else if (mem_rsp_valid)                  outst_q <= 1'b0;
    end

    assert_single_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
        outst_q |-> !mem_req_valid);

    assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_done_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_bad_desc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_fault == 3'd1) |-> (res_level == 3'd0 && !res_read && !res_write));

    assert_read_fault_perm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (res_fault == 3'd2 || res_fault == 3'd3)) |-> (!res_read && !res_write));

    assert_write_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_fault == 3'd4) |-> (res_read && !res_write));

    assert_leaf_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_fault == 3'd0) |-> (res_read && res_level >= 3'd1 && res_level <= 3'd4));
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .busy         (busy),
    .done         (done),
    .res_level    (res_level),
    .res_read     (res_read),
    .res_write    (res_write),
    .res_fault    (res_fault)
);

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;
    localparam int VA_W = 48;
    localparam int PA_W = 64;
    localparam int HAW  = 48;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [VA_W-1:0] req_iova = '0;
    logic            req_write = 1'b0;
    logic [PA_W-1:0] req_desc = '0;
    logic            mem_req_valid;
    logic            mem_req_ready = 1'b0;
    logic [PA_W-1:0] mem_req_addr;
    logic            mem_rsp_valid = 1'b0;
    logic [63:0]     mem_rsp_data = '0;
    logic            mem_rsp_err = 1'b0;
    logic            busy, done;
    logic [63:0]     res_entry;
    logic [2:0]      res_level;
    logic            res_read, res_write;
    logic [2:0]      res_fault;

    always #2.5 clk = ~clk;

    pt_walker #(.VA_W(VA_W), .PA_W(PA_W), .HAW(HAW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_iova(req_iova),
        .req_write(req_write), .req_desc(req_desc),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .busy(busy), .done(done), .res_entry(res_entry), .res_level(res_level),
        .res_read(res_read), .res_write(res_write), .res_fault(res_fault)
    );

    logic [63:0] mem  [logic [63:0]];
    bit          errs [logic [63:0]];
    int          n_checks = 0;
    int          n_fails  = 0;
    int          n_reads  = 0;
    bit          ready_always = 1'b0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // memory responder: all driving at the falling edge
    initial begin
        bit          acc = 1'b0;
        bit          pend = 1'b0;
        logic [63:0] acc_addr = '0;
        logic [63:0] p_addr = '0;
        int          lat = 0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
            if (acc) begin
                pend = 1'b1; p_addr = acc_addr; lat = int'($urandom % 3); acc = 1'b0;
                n_reads++;
            end
            if (pend) begin
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_err   = errs.exists(p_addr);
                    mem_rsp_data  = mem.exists(p_addr) ? mem[p_addr] : 64'd0;
                    pend = 1'b0;
                end else lat--;
            end
            mem_req_ready = ready_always ? 1'b1 : ($urandom % 2 == 0);
            acc      = mem_req_valid && mem_req_ready;
            acc_addr = mem_req_addr;
        end
    end

    function automatic logic [63:0] ent_addr(input logic [63:0] base, input logic [47:0] va, input int lvl);
        logic [8:0] idx = va[12 + (lvl-1)*9 +: 9];
        return base + {52'd0, idx, 3'b000};
    endfunction

    function automatic logic [63:0] strip_base(input logic [63:0] e);
        return {16'd0, e[47:12], 12'd0};
    endfunction

    // builds a chain of entries along the path of va; lvl 0 in a knob means none
    task automatic build_chain(input logic [47:0] va, input logic [63:0] desc, input bit rnd,
                               input int err_lvl, input int np_lvl, input int ro_lvl, input int ps_lvl);
        logic [63:0] base = {desc[63:12], 12'd0};
        mem.delete();
        errs.delete();
        for (int l = 4; l >= 1; l--) begin
            logic [63:0] a = ent_addr(base, va, l);
            logic [63:0] e = {$urandom, $urandom};
            e[0] = 1'b1; e[1] = 1'b1; e[7] = 1'b0;
            if (rnd) begin
                e[0] = ($urandom % 12 != 0);
                e[1] = ($urandom % 4 != 0);
                e[7] = ($urandom % 6 == 0);
            end
            if (l == np_lvl) e[0] = 1'b0;
            if (l == ro_lvl) e[1] = 1'b0;
            if (l == ps_lvl) e[7] = 1'b1;
            if (l == err_lvl) errs[a] = 1'b1;
            mem[a] = e;
            base = strip_base(e);
        end
    endtask

    // reference walk computed from the requirements
    task automatic model(input logic [47:0] va, input bit wr, input logic [63:0] desc,
                         output logic [2:0] flt, output logic [2:0] lvl, output bit rd,
                         output bit wp, output logic [63:0] ent, output int nrd);
        logic [63:0] base = {desc[63:12], 12'd0};
        bit w = 1'b1;
        flt = 3'd0; lvl = 3'd0; rd = 1'b0; wp = 1'b0; ent = 64'd0; nrd = 0;
        if (desc[3:2] != 2'd0) begin flt = 3'd1; return; end
        for (int l = 4; l >= 1; l--) begin
            logic [63:0] a = ent_addr(base, va, l);
            logic [63:0] e = mem.exists(a) ? mem[a] : 64'd0;
            nrd++;
            lvl = 3'(l);
            if (errs.exists(a)) begin flt = (l == 4) ? 3'd2 : 3'd3; return; end
            if (!e[0]) begin flt = 3'd3; return; end
            if (wr && !e[1]) begin flt = 3'd4; rd = 1'b1; return; end
            w = w & e[1];
            if (l == 1 || e[7]) begin rd = 1'b1; wp = w; ent = e; return; end
            base = strip_base(e);
        end
    endtask

    task automatic do_walk(input logic [47:0] va, input bit wr, input logic [63:0] desc, input string tag);
        logic [2:0]  e_flt, e_lvl;
        bit          e_rd, e_wp;
        logic [63:0] e_ent;
        int          e_nrd;
        model(va, wr, desc, e_flt, e_lvl, e_rd, e_wp, e_ent, e_nrd);
        @(negedge clk);
        n_reads   = 0;
        req_valid = 1'b1; req_iova = va; req_write = wr; req_desc = desc;
        chk({tag, " R9 ready when idle"}, 64'(req_ready), 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R9 busy after accept"}, 64'(busy), 64'd1);
        while (!done) @(negedge clk);
        chk({tag, " R1/R3/R4/R6/R7 fault"}, 64'(res_fault), 64'(e_flt));
        chk({tag, " R2/R8 level"}, 64'(res_level), 64'(e_lvl));
        chk({tag, " R5 read perm"}, 64'(res_read), 64'(e_rd));
        chk({tag, " R5 write perm"}, 64'(res_write), 64'(e_wp));
        chk({tag, " R7 entry"}, res_entry, e_ent);
        chk({tag, " R6/R10 read count"}, 64'(n_reads), 64'(e_nrd));
        @(negedge clk);
        chk({tag, " R9 done one cycle"}, 64'({done, busy}), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [47:0] va;
        logic [63:0] desc;
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        chk("reset R9 busy", 64'(busy), 64'd0);
        chk("reset R9 done", 64'(done), 64'd0);
        chk("reset R9 ready", 64'(req_ready), 64'd1);
        chk("reset R10 mem req", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;

        // directed: bad depth mode, no reads
        va = 48'h1234_5678_9abc; desc = 64'h0000_0000_1234_5004;
        build_chain(va, 64'h0000_0000_1234_5000, 0, 0, 0, 0, 0);
        do_walk(va, 1'b0, desc, "R1 mode1");
        desc[3:2] = 2'd3;
        do_walk(va, 1'b0, desc, "R1 mode3");
        // directed: full four-level walk, all writable; fixed ready for exact addresses
        ready_always = 1'b1;
        desc = 64'h0000_0000_0040_0ff0;
        build_chain(va, desc, 0, 0, 0, 0, 0);
        do_walk(va, 1'b1, desc, "R2 full walk");
        ready_always = 1'b0;
        build_chain(va, desc, 0, 4, 0, 0, 0);
        do_walk(va, 1'b0, desc, "R3 root error");
        build_chain(va, desc, 0, 2, 0, 0, 0);
        do_walk(va, 1'b0, desc, "R3 level2 error");
        build_chain(va, desc, 0, 0, 2, 0, 0);
        do_walk(va, 1'b0, desc, "R4 not present l2");
        build_chain(va, desc, 0, 0, 0, 3, 0);
        do_walk(va, 1'b0, desc, "R5 read-only l3 read");
        do_walk(va, 1'b1, desc, "R6 read-only l3 write");
        build_chain(va, desc, 0, 0, 0, 0, 3);
        do_walk(va, 1'b0, desc, "R7 large page l3");
        build_chain(va, desc, 0, 0, 0, 0, 4);
        do_walk(va, 1'b1, desc, "R7 large page l4");
        build_chain(48'hffff_ffff_ffff, desc, 0, 0, 0, 0, 0);
        do_walk(48'hffff_ffff_ffff, 1'b0, desc, "R8 top index");

        // random walks
        for (int t = 0; t < 400; t++) begin
            va   = {$urandom, $urandom};
            desc = {$urandom, $urandom};
            desc[3:2] = ($urandom % 10 == 0) ? 2'($urandom) : 2'd0;
            build_chain(va, desc, 1, ($urandom % 8 == 0) ? int'(1 + $urandom % 4) : 0, 0, 0, 0);
            do_walk(va, 1'($urandom), desc, "rand R1/R3/R4/R5/R6/R7/R8");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule